// File: doc/BRIEF.md
# Nested Fault Detector and Processor Hang Controller

This block keeps watch over the fault-class traps of a simple processor: hardware error, the fault cases of an instruction exception, and watchdog runout. The first such trap raises a fault-in-progress flag. While the flag is up, three interrupt classes are held off no matter what the loaded status words allow: processor fault, memory fault and count pulse. The trap handler lowers the flag when it finishes with a status-reload instruction whose two mode bits hold a specific pattern.

If another fault-class trap arrives before the flag is lowered, recovery can no longer be trusted. The block then stalls the processor. Only an operator command ends the stall: either the processor-reset command or the system-reset command. That command clears the fault state. It also emits a one-cycle sequence that tells the rest of the core to do three things: clear the fault status register and the fault-interrupt-generated flag, zero the status words, and load the instruction address with the restart location 0x26.

Top module: `fault_nest_ctrl`

## Requirements
- R1: A pulse on any of the three trap inputs while the flag is clear sets `fault_flag` at the next clock edge, and `cpu_hang` stays low.
- R2: `irq_inhibit` equals `psw_inhibit` OR-ed with a forced mask. The forced mask is bits 0 (processor fault), 1 (memory fault) and 2 (count pulse) while `fault_flag` is high, and zero while it is low.
- R3: With the flag set and no trap present, the flag clears at the next edge only when `psr_retire` is high with `psr_mode_b10`=0 and `psr_mode_b11`=1. Every other mode-bit pair leaves the flag set, and so does a mode-bit pair presented without `psr_retire`.
- R4: A trap that arrives while the flag is set raises `cpu_hang` at the next edge. The hang and the flag then hold through any further traps and status reloads until a reset command arrives.
- R5: Either `op_reset_cpu` or `op_reset_sys`, sampled at an edge, clears `fault_flag` and `cpu_hang` at that edge.
- R6: In the cycle after a rising edge of the combined reset command, `fault_status_clr`, `fault_irq_gen_clr`, `psw_clear` and `restart_load` are all high for exactly one cycle, and `restart_addr` reads 0x26. While the command stays held, these outputs stay low and `restart_addr` reads zero.
- R7: A trap and a clearing status reload in the same cycle, with the flag set, count as a second fault, so the block hangs.
- R8: A reset command takes priority over a trap sampled in the same cycle, so the flag stays clear.
- R9: After the asynchronous reset `rst_n`, the flag, the hang and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_hw_err | input | 1 | Hardware-error trap pulse |
| trap_insn_exc | input | 1 | Fault-class instruction-exception trap pulse |
| trap_wdog_run | input | 1 | Watchdog runout trap pulse |
| psr_retire | input | 1 | Status-reload instruction retires this cycle |
| psr_mode_b10 | input | 1 | Mode bit 10 of the retiring status reload |
| psr_mode_b11 | input | 1 | Mode bit 11 of the retiring status reload |
| op_reset_cpu | input | 1 | Operator processor-reset command |
| op_reset_sys | input | 1 | Operator system-reset command |
| psw_inhibit | input | IRQ_W | Interrupt inhibits from the loaded status words |
| fault_flag | output | 1 | Fault-in-progress flag |
| cpu_hang | output | 1 | Stall request after a nested fault |
| irq_inhibit | output | IRQ_W | Effective interrupt inhibits |
| fault_status_clr | output | 1 | One-cycle clear of the fault status register |
| fault_irq_gen_clr | output | 1 | One-cycle clear of the fault-interrupt-generated flag |
| psw_clear | output | 1 | One-cycle zeroing of the status words |
| restart_load | output | 1 | One-cycle load of the restart address |
| restart_addr | output | ADDR_W | Restart instruction address, valid while restart_load is high |

## Verification
The assertions assume three things about the inputs: they are synchronous to `clk`, they are known after reset, and a reset command is a level, not an edge. The checks on the strobes depend on that last point, because the one-cycle strobe is derived from the rising edge of that level. The bench changes every input one time unit after a rising edge, so each value is stable across the next sampling edge. It also holds reset commands for one or more whole cycles, and presents the mode bits both with and without the retire strobe.

// File: rtl/fnc_pkg.sv
package fnc_pkg;

    // Sequencer state of the fault-in-progress tracker
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HUNG  = 2'd2
    } fnc_state_e;

    // Number of fault-class trap sources that feed the tracker
    localparam int unsigned NUM_TRAPS = 3;

    // Bit positions of the interrupt classes forced off while a fault is open
    localparam int unsigned IRQ_PROC_FAULT_BIT = 0;
    localparam int unsigned IRQ_MEM_FAULT_BIT  = 1;
    localparam int unsigned IRQ_COUNT_BIT      = 2;

    typedef struct packed {
        fnc_state_e st;
        logic       flag;
        logic       hang;
    } seq_regs_t;

endpackage

// File: rtl/fnc_seq.sv
module fnc_seq
    import fnc_pkg::*;
#(
    parameter int unsigned N_TRAPS = NUM_TRAPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRAPS-1:0] trap_vec,
    input  logic               psr_retire,
    input  logic               psr_mode_b10,
    input  logic               psr_mode_b11,
    input  logic               rst_cmd,
    output logic               flag,
    output logic               hang
);

    seq_regs_t r_d, r_q;
    logic      any_fault;
    logic      clr_req;

    assign any_fault = |trap_vec;
    assign clr_req   = psr_retire & ~psr_mode_b10 & psr_mode_b11;

    always_comb begin
        r_d = r_q;
        if (rst_cmd) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (any_fault) r_d.st = ST_ARMED;
                end
                ST_ARMED: begin
                    // a new fault wins over a simultaneous clearing reload
                    if (any_fault)    r_d.st = ST_HUNG;
                    else if (clr_req) r_d.st = ST_IDLE;
                end
                ST_HUNG: begin
                    r_d.st = ST_HUNG;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
        r_d.flag = (r_d.st != ST_IDLE);
        r_d.hang = (r_d.st == ST_HUNG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, flag: 1'b0, hang: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign flag = r_q.flag;
    assign hang = r_q.hang;

    // R1
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && any_fault && !rst_cmd) |=> (flag && !hang));

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !hang && !any_fault && clr_req && !rst_cmd) |=> !flag);

    // R4
    hang_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && any_fault && !rst_cmd) |=> (hang && flag));

    // R4
    hang_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hang && !rst_cmd) |=> hang);

    // R5
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (!flag && !hang));

endmodule

// File: rtl/fnc_mask.sv
module fnc_mask #(
    parameter int unsigned          IRQ_W  = 8,
    parameter logic [IRQ_W-1:0]     FORCED = '0
) (
    input  logic             flag,
    input  logic [IRQ_W-1:0] psw_inh,
    output logic [IRQ_W-1:0] inh
);

    logic [IRQ_W-1:0] forced_now;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (FORCED[i]) begin : g_forced
            assign forced_now[i] = flag;
        end else begin : g_pass
            assign forced_now[i] = 1'b0;
        end
        assign inh[i] = psw_inh[i] | forced_now[i];
    end

endmodule

// File: rtl/fnc_restart.sv
module fnc_restart #(
    parameter int unsigned       ADDR_W       = 17,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_cmd,
    output logic              strobe,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic              cmd_seen;
        logic              strobe;
        logic [ADDR_W-1:0] addr;
    } rs_regs_t;

    rs_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.cmd_seen = rst_cmd;
        r_d.strobe   = rst_cmd & ~r_q.cmd_seen;
        r_d.addr     = r_d.strobe ? RESTART_ADDR : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe = r_q.strobe;
    assign addr   = r_q.addr;

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R6
    strobe_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(rst_cmd));

endmodule

// File: rtl/fault_nest_ctrl.sv
module fault_nest_ctrl
    import fnc_pkg::*;
#(
    parameter int unsigned IRQ_W        = 8,
    parameter int unsigned ADDR_W       = 17,
    parameter int unsigned RESTART_WORD = 'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_hw_err,
    input  logic              trap_insn_exc,
    input  logic              trap_wdog_run,
    input  logic              psr_retire,
    input  logic              psr_mode_b10,
    input  logic              psr_mode_b11,
    input  logic              op_reset_cpu,
    input  logic              op_reset_sys,
    input  logic [IRQ_W-1:0]  psw_inhibit,
    output logic              fault_flag,
    output logic              cpu_hang,
    output logic [IRQ_W-1:0]  irq_inhibit,
    output logic              fault_status_clr,
    output logic              fault_irq_gen_clr,
    output logic              psw_clear,
    output logic              restart_load,
    output logic [ADDR_W-1:0] restart_addr
);

    localparam logic [IRQ_W-1:0] FORCED_MASK =
        IRQ_W'((1 << IRQ_PROC_FAULT_BIT) | (1 << IRQ_MEM_FAULT_BIT) | (1 << IRQ_COUNT_BIT));
    localparam logic [ADDR_W-1:0] RESTART_ADDR = ADDR_W'(RESTART_WORD);

    logic [NUM_TRAPS-1:0] trap_vec;
    logic                 rst_cmd;
    logic                 strobe;

    assign trap_vec = {trap_wdog_run, trap_insn_exc, trap_hw_err};
    assign rst_cmd  = op_reset_cpu | op_reset_sys;

    fnc_seq #(.N_TRAPS(NUM_TRAPS)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_vec     (trap_vec),
        .psr_retire   (psr_retire),
        .psr_mode_b10 (psr_mode_b10),
        .psr_mode_b11 (psr_mode_b11),
        .rst_cmd      (rst_cmd),
        .flag         (fault_flag),
        .hang         (cpu_hang)
    );

    fnc_mask #(.IRQ_W(IRQ_W), .FORCED(FORCED_MASK)) mask_i (
        .flag    (fault_flag),
        .psw_inh (psw_inhibit),
        .inh     (irq_inhibit)
    );

    fnc_restart #(.ADDR_W(ADDR_W), .RESTART_ADDR(RESTART_ADDR)) restart_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_cmd (rst_cmd),
        .strobe  (strobe),
        .addr    (restart_addr)
    );

    assign fault_status_clr  = strobe;
    assign fault_irq_gen_clr = strobe;
    assign psw_clear         = strobe;
    assign restart_load      = strobe;

    // R2
    forced_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> ((irq_inhibit & FORCED_MASK) == FORCED_MASK));

    // R6
    restart_not_hung_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_load |-> (!cpu_hang && !fault_flag && restart_addr == RESTART_ADDR));

    // R4
    hang_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hang |-> fault_flag);

endmodule

// File: tb/fault_nest_ctrl_tb.sv
module fault_nest_ctrl_tb_top;

    localparam int IRQ_W  = 8;
    localparam int ADDR_W = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_hw_err = 0, trap_insn_exc = 0, trap_wdog_run = 0;
    logic psr_retire = 0, psr_mode_b10 = 0, psr_mode_b11 = 0;
    logic op_reset_cpu = 0, op_reset_sys = 0;
    logic [IRQ_W-1:0] psw_inhibit = '0;
    logic fault_flag, cpu_hang, fault_status_clr, fault_irq_gen_clr, psw_clear, restart_load;
    logic [IRQ_W-1:0] irq_inhibit;
    logic [ADDR_W-1:0] restart_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fault_nest_ctrl #(.IRQ_W(IRQ_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .trap_hw_err(trap_hw_err), .trap_insn_exc(trap_insn_exc), .trap_wdog_run(trap_wdog_run),
        .psr_retire(psr_retire), .psr_mode_b10(psr_mode_b10), .psr_mode_b11(psr_mode_b11),
        .op_reset_cpu(op_reset_cpu), .op_reset_sys(op_reset_sys),
        .psw_inhibit(psw_inhibit),
        .fault_flag(fault_flag), .cpu_hang(cpu_hang), .irq_inhibit(irq_inhibit),
        .fault_status_clr(fault_status_clr), .fault_irq_gen_clr(fault_irq_gen_clr),
        .psw_clear(psw_clear), .restart_load(restart_load), .restart_addr(restart_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance one clock and settle just after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        trap_hw_err = 0; trap_insn_exc = 0; trap_wdog_run = 0;
        psr_retire = 0; psr_mode_b10 = 0; psr_mode_b11 = 0;
        op_reset_cpu = 0; op_reset_sys = 0;
    endtask

    task automatic strobes_low(input string req);
        chk(req, {fault_status_clr, fault_irq_gen_clr, psw_clear, restart_load}, 0);
        chk(req, restart_addr, 0);
    endtask

    task automatic good_reload();
        psr_retire = 1; psr_mode_b10 = 0; psr_mode_b11 = 1;
        step();
        idle_inputs();
    endtask

    task automatic pulse_reset_cpu();
        op_reset_cpu = 1;
        step();
        idle_inputs();
        step();
    endtask

    task automatic t_reset_state();
        chk("R9 flag", fault_flag, 0);
        chk("R9 hang", cpu_hang, 0);
        strobes_low("R9 strobes");
        psw_inhibit = 8'h5A; #1;
        chk("R2 passthrough idle", irq_inhibit, 8'h5A);
        psw_inhibit = 8'h00;
    endtask

    task automatic t_each_source();
        for (int s = 0; s < 3; s++) begin
            trap_hw_err = (s == 0); trap_insn_exc = (s == 1); trap_wdog_run = (s == 2);
            step();
            idle_inputs();
            chk($sformatf("R1 flag src%0d", s), fault_flag, 1);
            chk($sformatf("R1 no hang src%0d", s), cpu_hang, 0);
            good_reload();
            chk($sformatf("R3 cleared src%0d", s), fault_flag, 0);
        end
    endtask

    task automatic t_mask();
        psw_inhibit = 8'hA0; #1;
        chk("R2 no force", irq_inhibit, 8'hA0);
        trap_hw_err = 1; step(); idle_inputs();
        chk("R2 forced or A0", irq_inhibit, 8'hA7);
        psw_inhibit = 8'h01; #1;
        chk("R2 forced or 01", irq_inhibit, 8'h07);
        psw_inhibit = 8'hFF; #1;
        chk("R2 forced or FF", irq_inhibit, 8'hFF);
        good_reload();
        psw_inhibit = 8'h00; #1;
        chk("R2 released", irq_inhibit, 8'h00);
    endtask

    task automatic t_bad_clear();
        trap_wdog_run = 1; step(); idle_inputs();
        psr_retire = 1; psr_mode_b10 = 0; psr_mode_b11 = 0; step(); idle_inputs();
        chk("R3 mode 00 keeps", fault_flag, 1);
        psr_retire = 1; psr_mode_b10 = 1; psr_mode_b11 = 0; step(); idle_inputs();
        chk("R3 mode 10 keeps", fault_flag, 1);
        psr_retire = 1; psr_mode_b10 = 1; psr_mode_b11 = 1; step(); idle_inputs();
        chk("R3 mode 11 keeps", fault_flag, 1);
        psr_retire = 0; psr_mode_b10 = 0; psr_mode_b11 = 1; step(); idle_inputs();
        chk("R3 no retire keeps", fault_flag, 1);
        good_reload();
        chk("R3 good clear", fault_flag, 0);
    endtask

    task automatic t_hang_cpu_reset();
        trap_insn_exc = 1; step(); idle_inputs();
        trap_hw_err = 1; step(); idle_inputs();
        chk("R4 hang", cpu_hang, 1);
        chk("R4 flag kept", fault_flag, 1);
        good_reload();
        chk("R4 reload ignored", cpu_hang, 1);
        trap_wdog_run = 1; step(); idle_inputs();
        for (int i = 0; i < 4; i++) step();
        chk("R4 still hung", cpu_hang, 1);
        strobes_low("R6 no strobe while hung");
        op_reset_cpu = 1; step(); idle_inputs();
        chk("R5 hang released", cpu_hang, 0);
        chk("R5 flag cleared", fault_flag, 0);
        chk("R6 strobes", {fault_status_clr, fault_irq_gen_clr, psw_clear, restart_load}, 4'hF);
        chk("R6 addr", restart_addr, 'h26);
        step();
        strobes_low("R6 one cycle");
    endtask

    task automatic t_hang_sys_reset_held();
        trap_hw_err = 1; step(); idle_inputs();
        trap_hw_err = 1; step(); idle_inputs();
        chk("R4 hang sys", cpu_hang, 1);
        op_reset_sys = 1; step();
        chk("R5 sys released", cpu_hang, 0);
        chk("R6 sys strobe", restart_load, 1);
        step();
        strobes_low("R6 held no repeat");
        step();
        strobes_low("R6 held no repeat 2");
        idle_inputs(); step();
        strobes_low("R6 after release");
    endtask

    task automatic t_same_cycle();
        trap_hw_err = 1; step(); idle_inputs();
        trap_wdog_run = 1; psr_retire = 1; psr_mode_b10 = 0; psr_mode_b11 = 1;
        step(); idle_inputs();
        chk("R7 fault wins", cpu_hang, 1);
        pulse_reset_cpu();
        chk("R7 recovered", cpu_hang, 0);
    endtask

    task automatic t_reset_vs_trap();
        trap_insn_exc = 1; op_reset_sys = 1; step(); idle_inputs();
        chk("R8 reset wins flag", fault_flag, 0);
        chk("R8 reset wins hang", cpu_hang, 0);
        step();
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        rst_n = 1;
        step();
        t_reset_state();
        t_each_source();
        t_mask();
        t_bad_clear();
        t_hang_cpu_reset();
        t_hang_sys_reset_held();
        t_same_cycle();
        t_reset_vs_trap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule